// File: doc/BRIEF.md
# Floating-Point Operate Register Specifier Decoder

This block accepts a 32-bit floating-point operate instruction word together with the trap-type code currently pending in the floating-point status, and produces a registered decode record: the 9-bit operation code, the operand size of each of the two sources and the destination, the physical 6-bit register index of each operand, and a verdict. The verdict says whether the operation is accepted. It also says whether the status trap-type field is rewritten, and with which value. The verdict is rejected for unknown operations, for a pending trap type that does not belong to the operation, and for quad operands that name a misaligned register.

Single operands address one 32-bit slot directly. Double and quad operands fold the low bit of their 5-bit field into the top bit of the 6-bit index, so that the upper half of a 64-slot file is reachable. A small side path turns a comparison outcome into a 2-bit condition code and raises a one-hot write strobe for the selected condition field. Operation execution and register storage are outside this block.

Top module: `fpop_spec_decoder`

## Requirements
- R1: An instruction belongs to group A when `(instr & 0xC1F80000) == 0x81A00000` and to group B when it equals `0x81A80000`. Only the listed group-A operation codes and the two group-B compare codes 0x053 and 0x057 are known. Any other word is rejected with `out_accept=0` and `out_ftt_we=0`, and all sizes and indices are 0.
- R2: The operation code comes from bits 13:5 and is echoed on `out_opf`. Source 1 is taken from bits 18:14, source 2 from bits 4:0 and the destination from bits 29:25.
- R3: A single operand (size code 1) has index `{0, field}`.
- R4: A double (size 2) or quad (size 3) operand has index `{field[0], field[4:1], 0}`.
- R5: Take a known operation whose trap type matches and which has a quad operand whose field has bit 1 set. It gives `out_accept=0`, `out_ftt_we=1` and `out_ftt_new=6`.
- R6: Quad operations expect pending type 3. Single and double operations expect 2. Single and double square root accept 2 or 3. On a mismatch the result is `out_accept=0` and `out_ftt_we=0`, and the mismatch takes precedence over R5.
- R7: An accepted operation gives `out_accept=1`, `out_ftt_we=1` and `out_ftt_new=0`.
- R8: An operand that the operation does not use reports size code 0 and index 0, whatever its field holds.
- R9: `in_ready` is high when the output is empty or being taken. A record appears one cycle after its input handshake and holds steady while `out_valid` is high and `out_ready` is low.
- R10: For a known compare, `out_cc_sel` equals instruction bits 26:25. For every other operation it is 0.
- R11: A cycle with `cc_valid` high makes `cc_we` one-hot at bit `cc_sel` on the next cycle. In that cycle `cc_val` maps the 3-bit two's-complement `cc_res` as 0→0, 1→1, −1→2, and anything else →3. Otherwise both outputs are 0.
- R12: After reset `out_valid`, `cc_we` and `cc_val` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Decoder can take an instruction |
| in_instr | input | 32 | Instruction word |
| in_pend_ftt | input | 3 | Pending trap-type code from status |
| out_valid | output | 1 | Decode record present |
| out_ready | input | 1 | Consumer takes the record |
| out_accept | output | 1 | Operation may proceed |
| out_ftt_we | output | 1 | Rewrite the status trap-type field |
| out_ftt_new | output | 3 | Value for the trap-type field |
| out_opf | output | 9 | Operation code |
| out_rs1_sz | output | 2 | Source 1 size code |
| out_rs2_sz | output | 2 | Source 2 size code |
| out_rd_sz | output | 2 | Destination size code |
| out_rs1_idx | output | 6 | Source 1 physical index |
| out_rs2_idx | output | 6 | Source 2 physical index |
| out_rd_idx | output | 6 | Destination physical index |
| out_cc_sel | output | 2 | Condition field chosen by a compare |
| cc_valid | input | 1 | Comparison outcome offered |
| cc_res | input | 3 | Comparison outcome, two's complement |
| cc_sel | input | 2 | Condition field to write |
| cc_we | output | 4 | One-hot condition field write strobe |
| cc_val | output | 2 | Condition code to write |

## Verification
The assertions assume that the consumer does not expect the record to change while it stalls. They also assume that `cc_sel` always names one of the four fields. The stimulus holds `in_valid` and its word steady until the handshake completes. It toggles `out_ready` in a pseudo-random pattern so that stalls occur, and it drives the compare path only with fields in range. It includes misaligned quad fields, mismatched pending codes and words outside both groups, so that the reject paths are exercised while the handshake stays legal.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
    parameter int FLD_W = 5;
    parameter int IDX_W = FLD_W + 1;
    parameter int FTT_W = 3;
    parameter int OPF_W = 9;
    parameter int NCC   = 4;
    parameter int CCS_W = $clog2(NCC);
    parameter int NOPND = 3;

    localparam logic [31:0] GRP_MASK = 32'hC1F8_0000;
    localparam logic [31:0] GRP_A    = 32'h81A0_0000;
    localparam logic [31:0] GRP_B    = 32'h81A8_0000;

    localparam logic [FTT_W-1:0] FTT_UNFIN  = 3'd2;
    localparam logic [FTT_W-1:0] FTT_UNIMP  = 3'd3;
    localparam logic [FTT_W-1:0] FTT_BADREG = 3'd6;

    typedef enum logic [1:0] {SZ_NONE, SZ_S, SZ_D, SZ_Q} sz_e;

    typedef struct packed {
        logic             known;
        logic             any_ftt;
        logic [FTT_W-1:0] ftt;
        sz_e              rd;
        sz_e              rs2;
        sz_e              rs1;
        logic             cmp;
    } desc_t;

    typedef struct packed {
        logic             accept;
        logic             ftt_we;
        logic [FTT_W-1:0] ftt_new;
        logic [OPF_W-1:0] opf;
        sz_e              rs1_sz;
        sz_e              rs2_sz;
        sz_e              rd_sz;
        logic [IDX_W-1:0] rs1_idx;
        logic [IDX_W-1:0] rs2_idx;
        logic [IDX_W-1:0] rd_idx;
        logic [CCS_W-1:0] cc_sel;
    } dec_t;

    function automatic desc_t mk(input logic [FTT_W-1:0] t, input logic any,
                                 input sz_e d, input sz_e b, input sz_e a,
                                 input logic c);
        desc_t r;
        r.known = 1'b1; r.any_ftt = any; r.ftt = t;
        r.rd = d; r.rs2 = b; r.rs1 = a; r.cmp = c;
        return r;
    endfunction

    function automatic desc_t lookup(input logic grp_b, input logic [OPF_W-1:0] opf);
        desc_t r;
        r = '0;
        if (grp_b) begin
            case (opf)
                9'h053, 9'h057: r = mk(FTT_UNIMP, 1'b0, SZ_NONE, SZ_Q, SZ_Q, 1'b1);
                default:        r = '0;
            endcase
        end else begin
            case (opf)
                9'h003, 9'h007, 9'h00b, 9'h02b:
                                r = mk(FTT_UNIMP, 1'b0, SZ_Q, SZ_Q, SZ_NONE, 1'b0);
                9'h043, 9'h047, 9'h04b, 9'h04f:
                                r = mk(FTT_UNIMP, 1'b0, SZ_Q, SZ_Q, SZ_Q, 1'b0);
                9'h06e:         r = mk(FTT_UNIMP, 1'b0, SZ_Q, SZ_D, SZ_D, 1'b0);
                9'h083, 9'h0cb: r = mk(FTT_UNIMP, 1'b0, SZ_D, SZ_Q, SZ_NONE, 1'b0);
                9'h08c, 9'h0ce: r = mk(FTT_UNIMP, 1'b0, SZ_Q, SZ_D, SZ_NONE, 1'b0);
                9'h0c7, 9'h0d3: r = mk(FTT_UNIMP, 1'b0, SZ_S, SZ_Q, SZ_NONE, 1'b0);
                9'h0cc, 9'h0cd: r = mk(FTT_UNIMP, 1'b0, SZ_Q, SZ_S, SZ_NONE, 1'b0);
                9'h029:         r = mk(FTT_UNFIN, 1'b1, SZ_S, SZ_S, SZ_NONE, 1'b0);
                9'h02a:         r = mk(FTT_UNFIN, 1'b1, SZ_D, SZ_D, SZ_NONE, 1'b0);
                9'h042, 9'h046, 9'h04a, 9'h04e:
                                r = mk(FTT_UNFIN, 1'b0, SZ_D, SZ_D, SZ_D, 1'b0);
                9'h041, 9'h045, 9'h049, 9'h04d:
                                r = mk(FTT_UNFIN, 1'b0, SZ_S, SZ_S, SZ_S, 1'b0);
                9'h069:         r = mk(FTT_UNFIN, 1'b0, SZ_D, SZ_S, SZ_S, 1'b0);
                9'h081, 9'h0c9, 9'h0c8:
                                r = mk(FTT_UNFIN, 1'b0, SZ_D, SZ_S, SZ_NONE, 1'b0);
                9'h082, 9'h088: r = mk(FTT_UNFIN, 1'b0, SZ_D, SZ_D, SZ_NONE, 1'b0);
                9'h0c6, 9'h0d2, 9'h084:
                                r = mk(FTT_UNFIN, 1'b0, SZ_S, SZ_D, SZ_NONE, 1'b0);
                9'h0d1:         r = mk(FTT_UNFIN, 1'b0, SZ_S, SZ_S, SZ_NONE, 1'b0);
                default:        r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [1:0] cc_encode(input logic [2:0] res);
        case (res)
            3'd0:    return 2'd0;
            3'd1:    return 2'd1;
            3'b111:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/fpd_opnd_map.sv
module fpd_opnd_map
    import fpd_pkg::*;
#(
    parameter int FW = FLD_W,
    parameter int IW = FW + 1
) (
    input  logic [FW-1:0] fld,
    input  sz_e           sz,
    output logic [IW-1:0] idx,
    output logic          bad
);
    always_comb begin
        idx = '0;
        bad = 1'b0;
        case (sz)
            SZ_S:       idx = {1'b0, fld};
            SZ_D:       idx = {fld[0], fld[FW-1:1], 1'b0};
            SZ_Q: begin
                        idx = {fld[0], fld[FW-1:1], 1'b0};
                        bad = fld[1];
            end
            default:    idx = '0;
        endcase
    end
endmodule

// File: rtl/fpd_cc_write.sv
module fpd_cc_write
    import fpd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [2:0]       res,
    input  logic [CCS_W-1:0] sel,
    output logic [NCC-1:0]   we,
    output logic [1:0]       val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we  <= '0;
            val <= '0;
        end else if (valid) begin
            we  <= NCC'(1) << sel;
            val <= cc_encode(res);
        end else begin
            we  <= '0;
            val <= '0;
        end
    end
endmodule

// File: rtl/fpop_spec_decoder.sv
module fpop_spec_decoder
    import fpd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_instr,
    input  logic [FTT_W-1:0] in_pend_ftt,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_accept,
    output logic             out_ftt_we,
    output logic [FTT_W-1:0] out_ftt_new,
    output logic [OPF_W-1:0] out_opf,
    output logic [1:0]       out_rs1_sz,
    output logic [1:0]       out_rs2_sz,
    output logic [1:0]       out_rd_sz,
    output logic [IDX_W-1:0] out_rs1_idx,
    output logic [IDX_W-1:0] out_rs2_idx,
    output logic [IDX_W-1:0] out_rd_idx,
    output logic [CCS_W-1:0] out_cc_sel,
    input  logic             cc_valid,
    input  logic [2:0]       cc_res,
    input  logic [CCS_W-1:0] cc_sel,
    output logic [NCC-1:0]   cc_we,
    output logic [1:0]       cc_val
);
    logic             in_grp_a, in_grp_b;
    logic [OPF_W-1:0] opf;
    desc_t            desc;
    logic [FLD_W-1:0] fld  [NOPND];
    sz_e              sz   [NOPND];
    logic [IDX_W-1:0] idx  [NOPND];
    logic [NOPND-1:0] bad_v;
    logic             ftt_ok;
    dec_t             nxt, held;

    assign in_grp_a = (in_instr & GRP_MASK) == GRP_A;
    assign in_grp_b = (in_instr & GRP_MASK) == GRP_B;
    assign opf      = in_instr[13:5];

    always_comb begin
        desc = lookup(in_grp_b, opf);
        if (!(in_grp_a || in_grp_b)) desc = '0;
    end

    // operand order: 0 = source 1, 1 = source 2, 2 = destination
    assign fld[0] = in_instr[18:14];
    assign fld[1] = in_instr[4:0];
    assign fld[2] = in_instr[29:25];
    assign sz[0]  = desc.rs1;
    assign sz[1]  = desc.rs2;
    assign sz[2]  = desc.rd;

    for (genvar k = 0; k < NOPND; k++) begin : g_opnd
        fpd_opnd_map #(.FW(FLD_W), .IW(IDX_W)) map_i (
            .fld (fld[k]),
            .sz  (sz[k]),
            .idx (idx[k]),
            .bad (bad_v[k])
        );
    end

    assign ftt_ok = desc.any_ftt ? (in_pend_ftt == FTT_UNFIN || in_pend_ftt == FTT_UNIMP)
                                 : (in_pend_ftt == desc.ftt);

    always_comb begin
        nxt         = '0;
        nxt.opf     = opf;
        nxt.rs1_sz  = desc.rs1;
        nxt.rs2_sz  = desc.rs2;
        nxt.rd_sz   = desc.rd;
        nxt.rs1_idx = idx[0];
        nxt.rs2_idx = idx[1];
        nxt.rd_idx  = idx[2];
        nxt.cc_sel  = desc.cmp ? in_instr[26:25] : '0;
        if (desc.known && ftt_ok) begin
            nxt.ftt_we  = 1'b1;
            nxt.accept  = ~|bad_v;
            nxt.ftt_new = (|bad_v) ? FTT_BADREG : '0;
        end
    end

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held      <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) held <= nxt;
        end
    end

    assign out_accept  = held.accept;
    assign out_ftt_we  = held.ftt_we;
    assign out_ftt_new = held.ftt_new;
    assign out_opf     = held.opf;
    assign out_rs1_sz  = held.rs1_sz;
    assign out_rs2_sz  = held.rs2_sz;
    assign out_rd_sz   = held.rd_sz;
    assign out_rs1_idx = held.rs1_idx;
    assign out_rs2_idx = held.rs2_idx;
    assign out_rd_idx  = held.rd_idx;
    assign out_cc_sel  = held.cc_sel;

    fpd_cc_write cc_i (
        .clk   (clk),
        .rst   (rst),
        .valid (cc_valid),
        .res   (cc_res),
        .sel   (cc_sel),
        .we    (cc_we),
        .val   (cc_val)
    );
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker
    import fpd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_accept,
    input logic             out_ftt_we,
    input logic [FTT_W-1:0] out_ftt_new,
    input logic [OPF_W-1:0] out_opf,
    input logic [1:0]       out_rs1_sz,
    input logic [1:0]       out_rs2_sz,
    input logic [1:0]       out_rd_sz,
    input logic [IDX_W-1:0] out_rs1_idx,
    input logic [IDX_W-1:0] out_rs2_idx,
    input logic [IDX_W-1:0] out_rd_idx,
    input logic             cc_valid,
    input logic [NCC-1:0]   cc_we
);
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid); // R9
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(out_opf) && $stable(out_rs1_idx)
            && $stable(out_rs2_idx) && $stable(out_rd_idx) && $stable(out_accept)); // R9
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_accept |-> out_ftt_we && out_ftt_new == '0); // R7
    AST_BADREG_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ftt_we && !out_accept |-> out_ftt_new == FTT_BADREG); // R5
    AST_QUAD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_accept && out_rs2_sz == 2'd3 |-> out_rs2_idx[1:0] == 2'b00); // R4
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_rs1_sz == 2'd0 |-> out_rs1_idx == '0); // R8
    AST_UNUSED_RD: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_rd_sz == 2'd0 |-> out_rd_idx == '0); // R8
    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cc_we)); // R11
    AST_CC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        cc_valid |=> $countones(cc_we) == 1); // R11
    AST_CC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cc_valid |=> cc_we == '0); // R11
    AST_TAKE_FILLS: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R9
endmodule

bind fpop_spec_decoder fpd_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_accept  (out_accept),
    .out_ftt_we  (out_ftt_we),
    .out_ftt_new (out_ftt_new),
    .out_opf     (out_opf),
    .out_rs1_sz  (out_rs1_sz),
    .out_rs2_sz  (out_rs2_sz),
    .out_rd_sz   (out_rd_sz),
    .out_rs1_idx (out_rs1_idx),
    .out_rs2_idx (out_rs2_idx),
    .out_rd_idx  (out_rd_idx),
    .cc_valid    (cc_valid),
    .cc_we       (cc_we)
);

// File: tb/fpop_spec_decoder_tb.sv
`timescale 1ns/1ps
module fpop_spec_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic [2:0]  in_pend_ftt = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_accept, out_ftt_we;
    logic [2:0]  out_ftt_new;
    logic [8:0]  out_opf;
    logic [1:0]  out_rs1_sz, out_rs2_sz, out_rd_sz, out_cc_sel;
    logic [5:0]  out_rs1_idx, out_rs2_idx, out_rd_idx;
    logic        cc_valid = 1'b0;
    logic [2:0]  cc_res = '0;
    logic [1:0]  cc_sel = '0;
    logic [3:0]  cc_we;
    logic [1:0]  cc_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit bp_on = 0;
    bit mon_on = 0;

    always #2.5 clk = ~clk;

    fpop_spec_decoder dut_i (.*);

    typedef struct {
        int    acc, fwe, fnew, opf, s1, s2, sd, i1, i2, id, ccs;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t staged;
    int   exp_we = 0, exp_val = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int map_idx(int fld, int sz);
        if (sz == 0) return 0;
        if (sz == 1) return fld;
        return ((fld & 1) << 5) | (fld & 5'h1e);
    endfunction

    function automatic bit [31:0] word(bit grp_b, int opf, int rd, int rs1, int rs2);
        return {2'b10, 5'(rd), 5'b11010, grp_b, 5'(rs1), 9'(opf), 5'(rs2)};
    endfunction

    // kind: 0 unknown, 2 or 3 required pending code, 4 either of 2 and 3
    function automatic exp_t model(bit [31:0] w, int pend, int kind,
                                   int sd, int s2, int s1, bit cmp, string tag);
        exp_t e;
        bit ok, bad;
        int f1, f2, fd;
        f1 = int'(w[18:14]); f2 = int'(w[4:0]); fd = int'(w[29:25]);
        e.tag = tag; e.opf = int'(w[13:5]);
        e.s1 = s1; e.s2 = s2; e.sd = sd;
        e.i1 = map_idx(f1, s1); e.i2 = map_idx(f2, s2); e.id = map_idx(fd, sd);
        e.ccs = cmp ? int'(w[26:25]) : 0;
        ok  = (kind == 4) ? (pend == 2 || pend == 3) : (kind != 0 && pend == kind);
        bad = (s1 == 3 && f1[1]) || (s2 == 3 && f2[1]) || (sd == 3 && fd[1]);
        e.acc = 0; e.fwe = 0; e.fnew = 0;
        if (ok) begin
            e.fwe = 1;
            if (bad) e.fnew = 6; else e.acc = 1;
        end
        return e;
    endfunction

    task automatic issue(bit [31:0] w, int pend, int kind, int sd, int s2, int s1,
                         bit cmp, string tag);
        staged = model(w, pend, kind, sd, s2, s1, cmp, tag);
        in_instr = w; in_pend_ftt = 3'(pend); in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R9", "out_valid", int'(out_valid), int'(q.size() != 0));
            if (out_valid && q.size() != 0) begin
                chk(q[0].tag, "accept",  int'(out_accept),  q[0].acc);
                chk(q[0].tag, "ftt_we",  int'(out_ftt_we),  q[0].fwe);
                chk(q[0].tag, "ftt_new", int'(out_ftt_new), q[0].fnew);
                chk(q[0].tag, "opf",     int'(out_opf),     q[0].opf);
                chk(q[0].tag, "rs1_sz",  int'(out_rs1_sz),  q[0].s1);
                chk(q[0].tag, "rs2_sz",  int'(out_rs2_sz),  q[0].s2);
                chk(q[0].tag, "rd_sz",   int'(out_rd_sz),   q[0].sd);
                chk(q[0].tag, "rs1_idx", int'(out_rs1_idx), q[0].i1);
                chk(q[0].tag, "rs2_idx", int'(out_rs2_idx), q[0].i2);
                chk(q[0].tag, "rd_idx",  int'(out_rd_idx),  q[0].id);
                chk(q[0].tag, "cc_sel",  int'(out_cc_sel),  q[0].ccs);
                if (out_ready) void'(q.pop_front());
            end
            chk("R11", "cc_we",  int'(cc_we),  exp_we);
            chk("R11", "cc_val", int'(cc_val), exp_val);
            if (in_valid && in_ready) q.push_back(staged);
        end
        if (rst || !cc_valid) begin
            exp_we = 0; exp_val = 0;
        end else begin
            exp_we = 1 << cc_sel;
            if (cc_res == 3'd0) exp_val = 0;
            else if (cc_res == 3'd1) exp_val = 1;
            else if (cc_res == 3'b111) exp_val = 2;
            else exp_val = 3;
        end
    end

    // stall pattern on the consumer side
    initial begin
        logic [7:0] lfsr = 8'hA5;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = bp_on ? lfsr[0] : 1'b1;
        end
    end

    task automatic cc_pulse(int res, int sel);
        cc_res = 3'(res); cc_sel = 2'(sel); cc_valid = 1'b1;
        @(posedge clk); #1;
        cc_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R12", "out_valid in reset", int'(out_valid), 0);
        chk("R12", "cc_we in reset", int'(cc_we), 0);
        chk("R12", "cc_val in reset", int'(cc_val), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        mon_on = 1;
        @(posedge clk); #1;

        // R3 single add: indices equal fields
        issue(word(0, 'h041, 31, 5, 7), 2, 2, 1, 1, 1, 0, "R3");
        // R4 double add: low bit folded to index bit 5 (5->36, 7->38, 30->30)
        issue(word(0, 'h042, 30, 5, 7), 2, 2, 2, 2, 2, 0, "R4");
        // R2 field positions with distinct values
        issue(word(0, 'h049, 1, 18, 9), 2, 2, 1, 1, 1, 0, "R2");
        // R7 aligned quad add accepted
        issue(word(0, 'h043, 12, 4, 8), 3, 3, 3, 3, 3, 0, "R7");
        // R5 quad source 2 misaligned
        issue(word(0, 'h043, 12, 4, 6), 3, 3, 3, 3, 3, 0, "R5");
        // R5 quad destination misaligned
        issue(word(0, 'h047, 14, 0, 8), 3, 3, 3, 3, 3, 0, "R5");
        // R6 quad op with unfinished pending code, misaligned too: mismatch wins
        issue(word(0, 'h043, 12, 4, 6), 2, 3, 3, 3, 3, 0, "R6");
        // R6 single op with pending 3
        issue(word(0, 'h045, 3, 3, 3), 3, 2, 1, 1, 1, 0, "R6");
        // R6 square roots take either code, reject others
        issue(word(0, 'h029, 9, 0, 11), 2, 4, 1, 1, 0, 0, "R6");
        issue(word(0, 'h02a, 9, 0, 11), 3, 4, 2, 2, 0, 0, "R6");
        issue(word(0, 'h029, 9, 0, 11), 0, 4, 1, 1, 0, 0, "R6");
        // R1 unknown code in group A, word outside both groups, unknown group B code
        issue(word(0, 'h1ff, 3, 3, 3), 2, 0, 0, 0, 0, 0, "R1");
        issue(32'h0000_0000, 3, 0, 0, 0, 0, 0, "R1");
        issue(word(1, 'h043, 3, 3, 3), 3, 0, 0, 0, 0, 0, "R1");
        // R10 quad compare: destination unused, cc field from bits 26:25
        issue(word(1, 'h053, 5'b00110, 8, 12), 3, 3, 0, 3, 3, 1, "R10");
        issue(word(1, 'h057, 5'b11011, 0, 4), 3, 3, 0, 3, 3, 1, "R10");
        // R8 unused source 1 with a nonzero field
        issue(word(0, 'h0d3, 7, 19, 16), 3, 3, 1, 3, 0, 0, "R8");
        // R4 mixed sizes: double result from single sources
        issue(word(0, 'h069, 21, 13, 14), 2, 2, 2, 1, 1, 0, "R4");

        // R9 back-to-back traffic under consumer stalls
        bp_on = 1;
        for (int i = 0; i < 40; i++) begin
            int f = (i * 7 + 3) % 32;
            case (i % 4)
                0: issue(word(0, 'h04e, f, 31 - f, f ^ 5), 2, 2, 2, 2, 2, 0, "R9");
                1: issue(word(0, 'h04b, f, f ^ 8, 31 - f), 3, 3, 3, 3, 3, 0, "R9");
                2: issue(word(0, 'h0c6, f, 0, f), 2, 2, 1, 2, 0, 0, "R9");
                default: issue(word(0, 'h0cd, f, 0, f), 3, 3, 3, 1, 0, 0, "R9");
            endcase
        end
        bp_on = 0;
        repeat (6) @(posedge clk);
        #1;

        // R11 compare outcome encoding and field strobe
        cc_pulse(0, 0);
        cc_pulse(1, 1);
        cc_pulse(7, 2);
        cc_pulse(3, 3);
        cc_pulse(2, 1);
        repeat (3) @(posedge clk);
        #1;

        chk("R9", "queue drained", q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule